// File: doc/BRIEF.md
# Cartridge Program and Character Bank Mapper

This block sits on the CPU write bus of a cartridge for an 8-bit game console. It watches CPU stores into the upper half of the address space and keeps a small set of bank registers. It then turns the CPU address into a program-ROM address and the video-bus address into a character-ROM address. A single register bit tells the console which way to mirror the nametables.

The program side has four 8 KB windows. The lower two windows are switchable. The upper two windows always show the last two banks of the program ROM. The character side has eight 1 KB windows, and each one is switchable. Bank numbers that go past the end of the ROM wrap modulo the bank count, and that count does not have to be a power of two. Both address translations are combinational. A register write takes effect on the clock edge where it is sampled.

Top module: `mapper_bank_ctl`

## Requirements
- R1: Register selection uses only the bits of `cpu_addr` kept by the mask 0xF003. For example, a write to 0x8FFC acts exactly like a write to 0x8000.
- R2: A write is ignored when its masked address matches no register. Examples are 0x8001, 0x9002, 0xB001, 0xF000, and any address below 0x8000. Every output then stays as it was.
- R3: A write to masked 0x8000 loads the bank for CPU window 0x8000–0x9FFF (`cpu_addr[14:13]`=0). While that window is addressed, `prg_rom_addr` = {bank, `cpu_addr[12:0]`}.
- R4: A write to masked 0xA000 loads the bank for CPU window 0xA000–0xBFFF (`cpu_addr[14:13]`=1). It forms the address in the same way as R3.
- R5: Window 0xC000–0xDFFF (`cpu_addr[14:13]`=2) always uses bank PRG_BANKS-2. Window 0xE000–0xFFFF (`cpu_addr[14:13]`=3) always uses bank PRG_BANKS-1.
- R6: The character window chosen by `ppu_addr[12:10]` = 0..7 is loaded from masked address 0xB000, 0xB002, 0xC000, 0xC002, 0xD000, 0xD002, 0xE000 or 0xE002, in that order. The output is `chr_rom_addr` = {bank, `ppu_addr[9:0]`}.
- R7: Bit 0 of a write to masked 0x9000 sets `mirror_horiz`: 0 selects vertical and 1 selects horizontal. The other data bits are ignored.
- R8: While `rst_n` is low, and after it is released, both switchable program banks and all eight character banks read as 0, and `mirror_horiz` is 0.
- R9: A write to one register leaves every other register unchanged.
- R10: A stored bank value is reduced modulo PRG_BANKS (program) or CHR_BANKS (character) before it is used. With 11 banks, a value of 200 selects bank 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| ppu_addr | input | 13 | Video-bus pattern address (0x0000–0x1FFF) |
| prg_rom_addr | output | $clog2(PRG_BANKS)+13 | Program-ROM byte address |
| chr_rom_addr | output | $clog2(CHR_BANKS)+10 | Character-ROM byte address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
A corrupted register does not show on its own. It appears on the output only when the matching window is addressed. A bad character slot shows up the first time `ppu_addr[12:10]` selects it, and a bad program bank the first time its CPU window is read. The bench therefore compares every output on every cycle against a behavioural model. It also sweeps both address buses widely, so a wrong register becomes visible within a few cycles of the write that caused it. Writes to mask aliases and to unmapped codes are mixed in, so that a decode error changes some output soon after the write that exposes it.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int CPU_AW    = 16;
    localparam int DATA_W    = 8;
    localparam int CHR_SLOTS = 8;
    localparam int SLOT_W    = $clog2(CHR_SLOTS);
    localparam int PPU_AW    = SLOT_W + 10;

    localparam logic [CPU_AW-1:0] ADDR_MASK  = 16'hF003;
    localparam logic [CPU_AW-1:0] SEL_PRG_LO = 16'h8000;
    localparam logic [CPU_AW-1:0] SEL_MIRROR = 16'h9000;
    localparam logic [CPU_AW-1:0] SEL_PRG_HI = 16'hA000;

    typedef struct packed {
        logic [DATA_W-1:0]                 prg_lo;
        logic [DATA_W-1:0]                 prg_hi;
        logic [CHR_SLOTS-1:0][DATA_W-1:0]  chr;
        logic                              mirror;
    } bank_state_t;

    // Pairs of slots share a high nibble; address bit 1 splits each pair.
    function automatic logic [CPU_AW-1:0] chr_sel_addr(input int slot);
        return CPU_AW'(32'hB000 + (slot / 2) * 32'h1000 + (slot % 2) * 2);
    endfunction
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_data,
    input  logic               cpu_wr,
    output bank_state_t        state_q
);
    bank_state_t        state_d;
    logic [CPU_AW-1:0]  masked;
    logic [CHR_SLOTS-1:0] chr_chg;

    always_comb begin
        state_d = state_q;
        masked  = cpu_addr & ADDR_MASK;
        if (cpu_wr) begin
            if (masked == SEL_PRG_LO) state_d.prg_lo = cpu_data;
            if (masked == SEL_PRG_HI) state_d.prg_hi = cpu_data;
            if (masked == SEL_MIRROR) state_d.mirror = cpu_data[0];
            for (int i = 0; i < CHR_SLOTS; i++) begin
                if (masked == chr_sel_addr(i)) state_d.chr[i] = cpu_data;
            end
        end
        for (int i = 0; i < CHR_SLOTS; i++) begin
            chr_chg[i] = (state_d.chr[i] != state_q.chr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_PRG_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr & ADDR_MASK) == SEL_PRG_LO) |=> state_q.prg_lo == $past(cpu_data)); // R3
    AST_PRG_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr & ADDR_MASK) == SEL_PRG_HI) |=> state_q.prg_hi == $past(cpu_data)); // R4
    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr & ADDR_MASK) == SEL_MIRROR) |=> state_q.mirror == $past(cpu_data[0])); // R7
    AST_LOW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[CPU_AW-1]) |=> $stable(state_q)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(state_q)); // R9
    AST_ONE_CHR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chr_chg)); // R9
endmodule

// File: rtl/prg_xlat.sv
module prg_xlat
    import mapper_pkg::*;
#(
    parameter int BANKS = 11,
    localparam int BW   = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [14:0]       cpu_off,
    input  logic [DATA_W-1:0] bank_lo,
    input  logic [DATA_W-1:0] bank_hi,
    output logic [BW+12:0]    rom_addr
);
    logic [BW-1:0] sel;

    always_comb begin
        unique case (cpu_off[14:13])
            2'd0:    sel = BW'(32'(bank_lo) % BANKS);
            2'd1:    sel = BW'(32'(bank_hi) % BANKS);
            2'd2:    sel = BW'(BANKS - 2);
            default: sel = BW'(BANKS - 1);
        endcase
        rom_addr = {sel, cpu_off[12:0]};
    end

    AST_PRG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rom_addr[BW+12:13]) < BANKS); // R10
    AST_PRG_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[12:0] == cpu_off[12:0]); // R3
endmodule

// File: rtl/chr_xlat.sv
module chr_xlat
    import mapper_pkg::*;
#(
    parameter int BANKS = 11,
    localparam int BW   = $clog2(BANKS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [PPU_AW-1:0]                ppu_addr,
    input  logic [CHR_SLOTS-1:0][DATA_W-1:0] banks,
    output logic [BW+9:0]                    rom_addr
);
    logic [DATA_W-1:0] raw;
    logic [BW-1:0]     sel;

    always_comb begin
        raw      = banks[ppu_addr[PPU_AW-1:10]];
        sel      = BW'(32'(raw) % BANKS);
        rom_addr = {sel, ppu_addr[9:0]};
    end

    AST_CHR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rom_addr[BW+9:10]) < BANKS); // R10
endmodule

// File: rtl/mapper_bank_ctl.sv
module mapper_bank_ctl
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 11,
    parameter int CHR_BANKS = 11,
    localparam int PRG_BW   = $clog2(PRG_BANKS),
    localparam int CHR_BW   = $clog2(CHR_BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_data,
    input  logic               cpu_wr,
    input  logic [12:0]        ppu_addr,
    output logic [PRG_BW+12:0] prg_rom_addr,
    output logic [CHR_BW+9:0]  chr_rom_addr,
    output logic               mirror_horiz
);
    bank_state_t state_q;

    mapper_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .state_q  (state_q)
    );

    prg_xlat #(.BANKS(PRG_BANKS)) prg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_off  (cpu_addr[14:0]),
        .bank_lo  (state_q.prg_lo),
        .bank_hi  (state_q.prg_hi),
        .rom_addr (prg_rom_addr)
    );

    chr_xlat #(.BANKS(CHR_BANKS)) chr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ppu_addr (ppu_addr),
        .banks    (state_q.chr),
        .rom_addr (chr_rom_addr)
    );

    assign mirror_horiz = state_q.mirror;

    AST_RESET_VERTICAL: assert property (@(posedge clk)
        !rst_n |-> !mirror_horiz); // R8
endmodule

// File: tb/mapper_bank_ctl_tb_top.sv
`timescale 1ns/1ps
module mapper_bank_ctl_tb_top;
    localparam int NP = 11;
    localparam int NC = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [$clog2(NP)+12:0] prg_rom_addr;
    logic [$clog2(NC)+9:0]  chr_rom_addr;
    logic        mirror_horiz;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    int m_lo, m_hi, m_mir;
    int m_chr [8];

    always #2.5 clk = ~clk;

    mapper_bank_ctl #(.PRG_BANKS(NP), .CHR_BANKS(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
        .chr_rom_addr(chr_rom_addr), .mirror_horiz(mirror_horiz)
    );

    task automatic model_clear();
        m_lo = 0; m_hi = 0; m_mir = 0;
        foreach (m_chr[i]) m_chr[i] = 0;
    endtask

    task automatic model_write(input int a, input int d);
        int k;
        k = a & 'hF003;
        if (k == 'h8000) m_lo = d;
        else if (k == 'hA000) m_hi = d;
        else if (k == 'h9000) m_mir = d % 2;
        else if (k == 'hB000) m_chr[0] = d;
        else if (k == 'hB002) m_chr[1] = d;
        else if (k == 'hC000) m_chr[2] = d;
        else if (k == 'hC002) m_chr[3] = d;
        else if (k == 'hD000) m_chr[4] = d;
        else if (k == 'hD002) m_chr[5] = d;
        else if (k == 'hE000) m_chr[6] = d;
        else if (k == 'hE002) m_chr[7] = d;
    endtask

    task automatic compare(input string ctx);
        int w, bank, ep, ec, slot;
        string tag;
        w = (int'(cpu_addr) / 8192) % 4;
        case (w)
            0: begin bank = m_lo % NP; tag = "R3"; end
            1: begin bank = m_hi % NP; tag = "R4"; end
            2: begin bank = NP - 2;    tag = "R5"; end
            default: begin bank = NP - 1; tag = "R5"; end
        endcase
        ep = bank * 8192 + (int'(cpu_addr) % 8192);
        slot = int'(ppu_addr) / 1024;
        ec = (m_chr[slot] % NC) * 1024 + (int'(ppu_addr) % 1024);
        vectors++;
        if (int'(prg_rom_addr) != ep) begin
            errors++;
            $display("FAIL %s prg_rom_addr act=%h exp=%h [%s]", tag, prg_rom_addr, ep, ctx);
        end
        if (int'(chr_rom_addr) != ec) begin
            errors++;
            $display("FAIL R6 chr_rom_addr act=%h exp=%h [%s]", chr_rom_addr, ec, ctx);
        end
        if (int'(mirror_horiz) != m_mir) begin
            errors++;
            $display("FAIL R7 mirror_horiz act=%0d exp=%0d [%s]", mirror_horiz, m_mir, ctx);
        end
    endtask

    task automatic step(input bit rs, input bit wr, input int a, input int d,
                        input int p, input string ctx);
        @(negedge clk);
        rst_n    = rs;
        cpu_wr   = wr;
        cpu_addr = 16'(a);
        cpu_data = 8'(d);
        ppu_addr = 13'(p);
        if (!rs) model_clear();
        @(posedge clk);
        if (rs && wr) model_write(a, d);
        #1;
        compare(ctx);
    endtask

    // Read sweep: every program window and every character slot.
    task automatic sweep(input string ctx);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0, 'h8000 + i * 'h1000 + i * 7, 0, i * 1024 + i * 13, ctx);
        end
    endtask

    initial begin
        model_clear();
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 'h8000 + i * 'h1000, 'h55, i * 1024, "R8 reset held");
        sweep("R8 after release");

        step(1'b1, 1'b1, 'h8000, 5, 0, "R3 load lo");
        step(1'b1, 1'b1, 'hA000, 3, 0, "R4 load hi");
        sweep("R3 R4 R5 windows");
        step(1'b1, 1'b1, 'h8FFC, 7, 0, "R1 alias 8FFC");
        step(1'b1, 1'b1, 'hBFF0, 9, 0, "R1 alias B000");
        sweep("R1 alias effect");
        step(1'b1, 1'b1, 'h8001, 1, 0, "R2 unmapped 8001");
        step(1'b1, 1'b1, 'h9002, 1, 0, "R2 unmapped 9002");
        step(1'b1, 1'b1, 'hB001, 2, 0, "R2 unmapped B001");
        step(1'b1, 1'b1, 'hF000, 4, 0, "R2 unmapped F000");
        step(1'b1, 1'b1, 'h7000, 4, 0, "R2 below 8000");
        step(1'b1, 1'b1, 'h2000, 4, 0, "R2 below 8000");
        sweep("R2 nothing changed");

        for (int s = 0; s < 8; s++) begin
            step(1'b1, 1'b1, 'hB000 + (s / 2) * 'h1000 + (s % 2) * 2, s + 1, s * 1024, "R6 slot load");
        end
        sweep("R6 R9 slot order");
        step(1'b1, 1'b1, 'hD002, 10, 5 * 1024, "R9 single slot rewrite");
        sweep("R9 neighbours kept");

        step(1'b1, 1'b1, 'h9000, 'hFE, 0, "R7 bit0 clear");
        step(1'b1, 1'b1, 'h9000, 'h01, 0, "R7 horizontal");
        step(1'b1, 1'b1, 'h9FF0, 'h02, 0, "R7 alias vertical");
        step(1'b1, 1'b1, 'h9000, 'h81, 0, "R7 horizontal again");

        step(1'b1, 1'b1, 'h8000, 200, 0, "R10 prg wrap");
        step(1'b1, 1'b1, 'hA000, 255, 'h1C00, "R10 prg wrap hi");
        step(1'b1, 1'b1, 'hE002, 255, 'h1C00, "R10 chr wrap");
        step(1'b1, 1'b1, 'hB000, 11, 0, "R10 chr exact count");
        sweep("R10 wrapped banks");

        for (int n = 0; n < 3000; n++) begin
            int a;
            a = int'($urandom) % 65536;
            if (n % 4 != 0) a = (a & 'hF003) | 'h8000;
            step(1'b1, ($urandom % 3) != 0, a, int'($urandom % 256),
                 int'($urandom % 8192), "R1 R2 R9 mixed traffic");
        end

        step(1'b0, 1'b0, 'hC000, 0, 'h0400, "R8 mid-run reset");
        step(1'b0, 1'b1, 'h8000, 9, 'h0800, "R8 write under reset");
        sweep("R8 state after reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        done = 1;
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule